// File: doc/BRIEF.md
# Legacy 1 MB Wraparound Mask Unit

This block sits on the physical-address path, after the core's address generator and before both the cache lookup and the outgoing memory bus cycle. An external active-low request pin asks the core to behave like an old 20-bit machine. In that mode any address that would cross the 1 MB boundary folds back below it, because bit 20 of the physical address is forced to zero.

The pin is synchronized before any use. A mask state, held in a register of its own, decides whether bit 20 is cleared. That state follows the pin freely only during a short capture window just after reset is released. After that window it changes only when the instruction pipeline signals a serialization point. Masking applies only to ordinary memory requests in real mode. Snoop and writeback requests pass through unchanged, and so does every request in system-management mode. A mask request seen in protected mode raises an undefined-operation flag. In that case the address passes through unmasked.

Top module: `wrap_mask_unit`

## Requirements
- R1: When the effective mask is active, the mode is real (mode_i = 0) and the request type is an ordinary memory access (cyc_type_i = 0), addr_o equals addr_i with bit 20 cleared. All other bits are unchanged, and the address path itself adds no register.
- R2: The pin mask_n_i is active low. It passes through two flops before use. A level sampled at clock edge P can be committed by a serialization pulse no earlier than edge P+2. A pulse at edge P+1 still sees the older level.
- R3: Snoop requests (cyc_type_i = 1) and writeback requests (cyc_type_i = 2) pass addr_i to addr_o unmodified, whatever the mask state.
- R4: In system-management mode (mode_i = 2), addr_o equals addr_i unmodified, whatever the pin or mask state.
- R5: In protected mode (mode_i = 1), undef_o is high exactly while the synchronized request is asserted, and addr_o equals addr_i. undef_o is low in every other mode.
- R6: Number the edges with reset released E1, E2 and so on. If the pin is first sampled low at E1, E2 or E3, the effective mask becomes active by E5 with no serialization pulse. If it is first sampled low at E4 or later, the mask stays inactive until a pulse arrives.
- R7: Once the capture window has closed, a change of the synchronized pin has no effect on addr_o or on the mask state until serialize_i is sampled high.
- R8: While rst_ni is low, the effective mask is inactive, the synchronized request is deasserted, undef_o is low and mask_chg_o is low.
- R9: mask_chg_o is high for exactly the one cycle that follows each clock edge at which the effective mask changes value, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_n_i | input | 1 | Raw wraparound-mask request pin, active low, may be asynchronous |
| mode_i | input | 2 | Operating mode: 0 real, 1 protected, 2 system management |
| cyc_type_i | input | 2 | Request type: 0 memory, 1 snoop, 2 writeback |
| serialize_i | input | 1 | Serialization point pulse from the pipeline |
| addr_i | input | AW | Physical address from the address generator |
| addr_o | output | AW | Physical address toward the cache and bus logic |
| undef_o | output | 1 | Mask requested while in protected mode |
| mask_chg_o | output | 1 | One-cycle strobe when the effective mask changes |

## Verification
addr_o and undef_o are combinational from the mode, the request type and registered state, so they are sampled one time unit after the edge on which that state settles. A pin level takes two edges to reach the synchronized request. A serialization pulse at an edge changes the mask and raises the strobe after that same edge. The strobe falls after the next edge. The bench drives every input just after a rising edge and checks just after the following one. The capture-window cases count edges from the release of reset, so a pin first sampled low at E1, E2 or E3 is expected to be masked and one first sampled low at E4 or E5 is expected to stay unmasked.

// File: rtl/wrap_mask_pkg.sv
package wrap_mask_pkg;
  localparam logic [1:0] MODE_REAL = 2'd0;
  localparam logic [1:0] MODE_PROT = 2'd1;
  localparam logic [1:0] MODE_SMM  = 2'd2;

  localparam logic [1:0] CYC_MEM   = 2'd0;
  localparam logic [1:0] CYC_SNOOP = 2'd1;
  localparam logic [1:0] CYC_WB    = 2'd2;
endpackage

// File: rtl/wrap_pin_sync.sv
module wrap_pin_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wrap_mask_state.sv
module wrap_mask_state #(
  parameter int unsigned WIN_LIM = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic serialize_i,
  output logic eff_o,
  output logic chg_o
);
  localparam int unsigned CW = $clog2(WIN_LIM + 1);
  localparam logic [CW-1:0] LIM = CW'(WIN_LIM);

  logic [CW-1:0] win_q;
  logic          win_open;
  logic          eff_q, eff_d, chg_q;

  assign win_open = (win_q < LIM);
  // free follow during capture window, otherwise only at serialization
  assign eff_d    = (win_open || serialize_i) ? req_i : eff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      eff_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      if (win_open) win_q <= win_q + 1'b1;
      eff_q <= eff_d;
      chg_q <= eff_d ^ eff_q;
    end
  end

  assign eff_o = eff_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/wrap_addr_gate.sv
module wrap_addr_gate
  import wrap_mask_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned MASK_BIT = 20
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    cyc_type_i,
  input  logic          eff_i,
  input  logic          req_i,
  output logic [AW-1:0] addr_o,
  output logic          undef_o
);
  localparam logic [AW-1:0] CLR = ~(AW'(1) << MASK_BIT);

  logic apply;

  assign apply   = eff_i && (mode_i == MODE_REAL) && (cyc_type_i == CYC_MEM);
  assign addr_o  = apply ? (addr_i & CLR) : addr_i;
  assign undef_o = req_i && (mode_i == MODE_PROT);
endmodule

// File: rtl/wrap_mask_unit.sv
module wrap_mask_unit #(
  parameter int unsigned AW          = 32,
  parameter int unsigned MASK_BIT    = 20,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WIN_EDGES   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_n_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    cyc_type_i,
  input  logic          serialize_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          undef_o,
  output logic          mask_chg_o
);
  localparam int unsigned WIN_LIM = WIN_EDGES + SYNC_STAGES;

  logic pin_s, req, eff;

  wrap_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mask_n_i),
    .q_o   (pin_s)
  );

  assign req = ~pin_s;

  wrap_mask_state #(.WIN_LIM(WIN_LIM)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .serialize_i(serialize_i),
    .eff_o      (eff),
    .chg_o      (mask_chg_o)
  );

  wrap_addr_gate #(.AW(AW), .MASK_BIT(MASK_BIT)) u_gate (
    .addr_i    (addr_i),
    .mode_i    (mode_i),
    .cyc_type_i(cyc_type_i),
    .eff_i     (eff),
    .req_i     (req),
    .addr_o    (addr_o),
    .undef_o   (undef_o)
  );
endmodule

// File: rtl/wrap_mask_unit_chk.sv
module wrap_mask_unit_chk
  import wrap_mask_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned MASK_BIT = 20,
  parameter int unsigned WIN_LIM  = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic [1:0]    cyc_type_i,
  input logic          serialize_i,
  input logic [AW-1:0] addr_i,
  input logic [AW-1:0] addr_o,
  input logic          undef_o,
  input logic          mask_chg_o
);
  localparam int unsigned CW = $clog2(WIN_LIM + 1);
  localparam logic [AW-1:0] KEEP = ~(AW'(1) << MASK_BIT);

  logic [CW-1:0] edges_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    edges_q <= '0;
    else if (edges_q < CW'(WIN_LIM)) edges_q <= edges_q + 1'b1;
  end

  assert_other_bits_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o & KEEP) == (addr_i & KEEP));

  assert_snoop_wb_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_type_i != CYC_MEM) |-> (addr_o == addr_i));

  assert_smm_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SMM) |-> (addr_o == addr_i && !undef_o));

  assert_prot_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PROT) |-> (addr_o == addr_i));

  assert_hold_no_serialize_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q >= CW'(WIN_LIM) && !serialize_i) |=> !mask_chg_o);

  always_comb begin
    if (!rst_ni) assert_reset_quiet_R8: assert (!mask_chg_o && !undef_o);
  end
endmodule

bind wrap_mask_unit wrap_mask_unit_chk #(
  .AW(AW), .MASK_BIT(MASK_BIT), .WIN_LIM(WIN_EDGES + SYNC_STAGES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .cyc_type_i (cyc_type_i),
  .serialize_i(serialize_i),
  .addr_i     (addr_i),
  .addr_o     (addr_o),
  .undef_o    (undef_o),
  .mask_chg_o (mask_chg_o)
);

// File: tb/wrap_mask_unit_bench.sv
module wrap_mask_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mask_n_i = 1'b1;
  logic [1:0]    mode_i = 2'd0;
  logic [1:0]    cyc_type_i = 2'd0;
  logic          serialize_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic          undef_o, mask_chg_o;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wrap_mask_unit u_wrap_mask_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .mask_n_i(mask_n_i), .mode_i(mode_i),
    .cyc_type_i(cyc_type_i), .serialize_i(serialize_i), .addr_i(addr_i),
    .addr_o(addr_o), .undef_o(undef_o), .mask_chg_o(mask_chg_o)
  );

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] a, logic eff,
                                             logic [1:0] m, logic [1:0] c);
    return (eff && m == 2'd0 && c == 2'd0) ? (a & ~(32'h1 << 20)) : a;
  endfunction

  // sweep modes, request types and address patterns with a given mask state
  task automatic sweep(logic eff, logic req);
    logic [AW-1:0] pats [4] = '{32'h0010_0000, 32'hFFFF_FFFF, 32'h001F_FFF0, 32'h0000_1234};
    for (int m = 0; m < 3; m++)
      for (int c = 0; c < 3; c++)
        for (int p = 0; p < 4; p++) begin
          mode_i = 2'(m); cyc_type_i = 2'(c); addr_i = pats[p];
          #1;
          if (m == 0 && c == 0) chk("R1", addr_o, exp_addr(pats[p], eff, 2'(m), 2'(c)));
          else if (m == 1)      chk("R5", addr_o, pats[p]);
          else if (m == 2)      chk("R4", addr_o, pats[p]);
          else                  chk("R3", addr_o, pats[p]);
          chk("R5", AW'(undef_o), AW'(req && m == 1));
        end
    mode_i = 2'd0; cyc_type_i = 2'd0; addr_i = 32'h0010_0000;
  endtask

  // pin first sampled low at edge E(k+1) after reset release
  task automatic window_case(int k);
    rst_ni = 1'b0; mask_n_i = 1'b1; serialize_i = 1'b0;
    mode_i = 2'd0; cyc_type_i = 2'd0; addr_i = 32'h0010_0000;
    tick(); tick();
    rst_ni = 1'b1;
    if (k == 0) mask_n_i = 1'b0;
    for (int i = 0; i < k; i++) tick();
    mask_n_i = 1'b0;
    for (int i = k; i < 8; i++) tick();
    chk($sformatf("R6 k=%0d", k), addr_o, (k <= 2) ? 32'h0 : 32'h0010_0000);
  endtask

  initial begin
    mode_i = 2'd0; cyc_type_i = 2'd0; addr_i = 32'h0010_0000;
    tick(); tick();
    // reset state
    chk("R8 chg", AW'(mask_chg_o), '0);
    chk("R8 undef", AW'(undef_o), '0);
    chk("R8 addr", addr_o, 32'h0010_0000);
    mode_i = 2'd1; #1;
    chk("R8 prot undef", AW'(undef_o), '0);
    mode_i = 2'd0;

    // release with pin high, let the window close
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) tick();
    chk("R9 idle", AW'(mask_chg_o), '0);
    sweep(1'b0, 1'b0);

    // pin low after window: no effect without a serialization pulse
    mask_n_i = 1'b0;                 // sampled at P1
    tick();                          // P1
    serialize_i = 1'b1;
    tick();                          // P2: old level still at sync output
    serialize_i = 1'b0;
    chk("R2 early pulse", addr_o, 32'h0010_0000);
    chk("R2 no strobe", AW'(mask_chg_o), '0);
    for (int i = 0; i < 5; i++) tick();
    chk("R7 hold", addr_o, 32'h0010_0000);
    chk("R7 no strobe", AW'(mask_chg_o), '0);
    sweep(1'b0, 1'b1);

    serialize_i = 1'b1;
    tick();
    serialize_i = 1'b0;
    chk("R1 applied", addr_o, 32'h0);
    chk("R9 strobe", AW'(mask_chg_o), 32'h1);
    tick();
    chk("R9 one cycle", AW'(mask_chg_o), '0);
    sweep(1'b1, 1'b1);

    // pin high again: mask held until serialize
    mask_n_i = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    chk("R7 held on", addr_o, 32'h0);
    serialize_i = 1'b1;
    tick();
    serialize_i = 1'b0;
    chk("R9 strobe off", AW'(mask_chg_o), 32'h1);
    chk("R1 released", addr_o, 32'h0010_0000);
    tick();
    chk("R9 off one cycle", AW'(mask_chg_o), '0);

    for (int k = 0; k < 5; k++) window_case(k);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule